// File: doc/BRIEF.md
# Dual-Port Hierarchical Word-Line Decoder

This block turns a 16-bit word address into the select lines that open one 16-bit word in a 64K x 16 memory array. The array is organised as four quadrants. Each quadrant holds eight local blocks of 256 rows by 128 columns, so one row carries eight 16-bit words. Decoding proceeds in three gated levels. The quadrant comes first. The local block inside that quadrant comes next. The row and the column group inside that block come last. The row address is split into two halves that are predecoded separately and then combined, which keeps each decode stage shallow.

Two complete decode paths exist, one for the read port and one for the write port. A read and a write can therefore be decoded in the same cycle, even when both target the same block. Each path starts only when its enable and its access strobe are both high. When either is low, no select line of that path toggles. On the write path, the column-group select is combined with the selected block to form a per-block word-write enable, so only the columns of the addressed word in the addressed block are written. All selects are registered and appear one clock after the address is presented.

Top module: `hwd_dual_decoder`

## Requirements
- R1: One cycle after a gated access (enable and strobe both 1), the quadrant select of that port is one-hot, with bit `addr[15:14]` set.
- R2: In the same cycle, the local-block select is one-hot, with bit `addr[13:11]` set.
- R3: In the same cycle, the row select is one-hot over 256 lines, with bit `addr[10:3]` set.
- R4: In the same cycle, the column-group select is one-hot over 8 lines, with bit `addr[2:0]` set.
- R5: When enable or strobe of a port is 0 at a clock edge, every select output of that port is all-zero after that edge, whatever the address.
- R6: While reset (active-low, asynchronous) is asserted, every select output is all-zero.
- R7: The read and write paths are independent. Each follows only its own enable, strobe and address, and both assert their selects when they address the same block in the same cycle.
- R8: The write word enable has 256 bits. Bit `((quad*8 + block)*8 + colgroup)` is 1 one cycle after a gated write. All other bits are 0, and all bits are 0 after an ungated write.
- R9: Every select vector has at most one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read port enable |
| rd_strobe | input | 1 | Read access strobe |
| rd_addr | input | 16 | Read word address |
| wr_en | input | 1 | Write port enable |
| wr_strobe | input | 1 | Write access strobe |
| wr_addr | input | 16 | Write word address |
| rd_quad_sel | output | 4 | Read quadrant select, one-hot |
| rd_blk_sel | output | 8 | Read local-block select, one-hot |
| rd_row_sel | output | 256 | Read row select, one-hot |
| rd_col_sel | output | 8 | Read column-group select, one-hot |
| wr_quad_sel | output | 4 | Write quadrant select, one-hot |
| wr_blk_sel | output | 8 | Write local-block select, one-hot |
| wr_row_sel | output | 256 | Write row select, one-hot |
| wr_col_sel | output | 8 | Write column-group select, one-hot |
| wr_word_en | output | 256 | Per-block, per-column-group write enable |

## Verification
The bench builds the block with its default field widths: 2 quadrant bits, 3 block bits, 8 row bits and 3 column bits. At these values the extreme quadrants, the last row (255) and both ends of the 256-bit word-enable vector can be reached directly from an address. They also make it cheap to compute the expected vectors by division and remainder on the address instead of by bit slicing. The vectors exercise same-block collisions between the two ports and each gating input on its own, one at a time.

// File: rtl/hwd_pkg.sv
`timescale 1ns/1ps
package hwd_pkg;

  // Number of lines produced by a binary field of the given width.
  function automatic int unsigned lines_of(input int unsigned bits);
    return 32'd1 << bits;
  endfunction

  // Width of the low half of a split row predecode.
  function automatic int unsigned low_half(input int unsigned bits);
    return bits - (bits / 2);
  endfunction

endpackage

// File: rtl/hwd_predec.sv
`timescale 1ns/1ps
// Gated binary-to-one-hot stage.
module hwd_predec #(
  parameter int unsigned CODE_W = 2,
  localparam int unsigned LINES = hwd_pkg::lines_of(CODE_W)
) (
  input  logic [CODE_W-1:0] code,
  input  logic              go,
  output logic [LINES-1:0]  lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = go && (code == CODE_W'(i));
  end
endmodule

// File: rtl/hwd_port_path.sv
`timescale 1ns/1ps
// One complete three-level decode path for one port.
module hwd_port_path #(
  parameter int unsigned Q_BITS = 2,
  parameter int unsigned B_BITS = 3,
  parameter int unsigned R_BITS = 8,
  parameter int unsigned C_BITS = 3,
  localparam int unsigned A_W   = Q_BITS + B_BITS + R_BITS + C_BITS,
  localparam int unsigned NQ    = hwd_pkg::lines_of(Q_BITS),
  localparam int unsigned NB    = hwd_pkg::lines_of(B_BITS),
  localparam int unsigned NR    = hwd_pkg::lines_of(R_BITS),
  localparam int unsigned NC    = hwd_pkg::lines_of(C_BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           strobe,
  input  logic [A_W-1:0] addr,
  output logic [NQ-1:0]  quad_q,
  output logic [NB-1:0]  blk_q,
  output logic [NR-1:0]  row_q,
  output logic [NC-1:0]  col_q
);
  localparam int unsigned LO_W = hwd_pkg::low_half(R_BITS);
  localparam int unsigned HI_W = R_BITS - LO_W;
  localparam int unsigned N_LO = hwd_pkg::lines_of(LO_W);
  localparam int unsigned N_HI = hwd_pkg::lines_of(HI_W);

  // Address fields.
  logic [C_BITS-1:0] f_col;
  logic [R_BITS-1:0] f_row;
  logic [B_BITS-1:0] f_blk;
  logic [Q_BITS-1:0] f_quad;
  assign f_col  = addr[C_BITS-1:0];
  assign f_row  = addr[C_BITS +: R_BITS];
  assign f_blk  = addr[C_BITS+R_BITS +: B_BITS];
  assign f_quad = addr[A_W-1 -: Q_BITS];

  // Named internal events.
  logic stage_go;   // enable combined with strobe at the first level
  logic lvl1_any;   // a quadrant line is active
  logic lvl2_any;   // a local block line is active
  assign stage_go = en & strobe;

  logic [NQ-1:0]   quad_d;
  logic [NB-1:0]   blk_d;
  logic [NC-1:0]   col_d;
  logic [N_HI-1:0] pre_hi;
  logic [N_LO-1:0] pre_lo;
  logic [NR-1:0]   row_d;

  hwd_predec #(.CODE_W(Q_BITS)) u_quad (.code(f_quad), .go(stage_go), .lines(quad_d));
  assign lvl1_any = |quad_d;

  hwd_predec #(.CODE_W(B_BITS)) u_blk (.code(f_blk), .go(lvl1_any), .lines(blk_d));
  assign lvl2_any = |blk_d;

  hwd_predec #(.CODE_W(HI_W)) u_pre_hi (
    .code(f_row[R_BITS-1:LO_W]), .go(lvl2_any), .lines(pre_hi));
  hwd_predec #(.CODE_W(LO_W)) u_pre_lo (
    .code(f_row[LO_W-1:0]), .go(lvl2_any), .lines(pre_lo));
  hwd_predec #(.CODE_W(C_BITS)) u_col (.code(f_col), .go(lvl2_any), .lines(col_d));

  // Final row decode: combine the two predecoded halves.
  for (genvar r = 0; r < NR; r++) begin : g_row
    assign row_d[r] = pre_hi[r / N_LO] & pre_lo[r % N_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q <= '0;
      blk_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      quad_q <= quad_d;
      blk_q  <= blk_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  // R1
  quad_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go |=> quad_q == (NQ'(1) << $past(f_quad)));
  // R2
  blk_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go |=> blk_q == (NB'(1) << $past(f_blk)));
  // R3
  row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go |=> row_q == (NR'(1) << $past(f_row)));
  // R4
  col_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go |=> col_q == (NC'(1) << $past(f_col)));
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && strobe) |=> (quad_q == '0 && blk_q == '0 && row_q == '0 && col_q == '0));
  // R9
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(quad_q) && $onehot0(blk_q) && $onehot0(row_q) && $onehot0(col_q));
endmodule

// File: rtl/hwd_word_gate.sv
`timescale 1ns/1ps
// Combines block selection with the column-group select per block.
module hwd_word_gate #(
  parameter int unsigned NQ = 4,
  parameter int unsigned NB = 8,
  parameter int unsigned NC = 8,
  localparam int unsigned NW = NQ * NB * NC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] quad_sel,
  input  logic [NB-1:0] blk_sel,
  input  logic [NC-1:0] col_sel,
  output logic [NW-1:0] word_en
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    for (genvar b = 0; b < NB; b++) begin : g_b
      logic blk_open;
      assign blk_open = quad_sel[q] & blk_sel[b];
      for (genvar c = 0; c < NC; c++) begin : g_c
        assign word_en[(q*NB + b)*NC + c] = blk_open & col_sel[c];
      end
    end
  end

  // R8
  word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_en) <= 1);
  // R8
  word_needs_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|word_en) |-> (|col_sel && |blk_sel && |quad_sel));
endmodule

// File: rtl/hwd_dual_decoder.sv
`timescale 1ns/1ps
module hwd_dual_decoder #(
  parameter int unsigned Q_BITS = 2,
  parameter int unsigned B_BITS = 3,
  parameter int unsigned R_BITS = 8,
  parameter int unsigned C_BITS = 3,
  localparam int unsigned A_W   = Q_BITS + B_BITS + R_BITS + C_BITS,
  localparam int unsigned NQ    = hwd_pkg::lines_of(Q_BITS),
  localparam int unsigned NB    = hwd_pkg::lines_of(B_BITS),
  localparam int unsigned NR    = hwd_pkg::lines_of(R_BITS),
  localparam int unsigned NC    = hwd_pkg::lines_of(C_BITS),
  localparam int unsigned NW    = NQ * NB * NC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic           rd_strobe,
  input  logic [A_W-1:0] rd_addr,
  input  logic           wr_en,
  input  logic           wr_strobe,
  input  logic [A_W-1:0] wr_addr,
  output logic [NQ-1:0]  rd_quad_sel,
  output logic [NB-1:0]  rd_blk_sel,
  output logic [NR-1:0]  rd_row_sel,
  output logic [NC-1:0]  rd_col_sel,
  output logic [NQ-1:0]  wr_quad_sel,
  output logic [NB-1:0]  wr_blk_sel,
  output logic [NR-1:0]  wr_row_sel,
  output logic [NC-1:0]  wr_col_sel,
  output logic [NW-1:0]  wr_word_en
);
  hwd_port_path #(.Q_BITS(Q_BITS), .B_BITS(B_BITS), .R_BITS(R_BITS), .C_BITS(C_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .en(rd_en), .strobe(rd_strobe), .addr(rd_addr),
    .quad_q(rd_quad_sel), .blk_q(rd_blk_sel), .row_q(rd_row_sel), .col_q(rd_col_sel));

  hwd_port_path #(.Q_BITS(Q_BITS), .B_BITS(B_BITS), .R_BITS(R_BITS), .C_BITS(C_BITS)) u_wr (
    .clk(clk), .rst_n(rst_n), .en(wr_en), .strobe(wr_strobe), .addr(wr_addr),
    .quad_q(wr_quad_sel), .blk_q(wr_blk_sel), .row_q(wr_row_sel), .col_q(wr_col_sel));

  hwd_word_gate #(.NQ(NQ), .NB(NB), .NC(NC)) u_wgate (
    .clk(clk), .rst_n(rst_n), .quad_sel(wr_quad_sel), .blk_sel(wr_blk_sel),
    .col_sel(wr_col_sel), .word_en(wr_word_en));

  // R7
  dual_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_strobe && wr_en && wr_strobe && rd_addr[A_W-1:C_BITS+R_BITS] == wr_addr[A_W-1:C_BITS+R_BITS])
    |=> (rd_blk_sel == wr_blk_sel && rd_quad_sel == wr_quad_sel && rd_blk_sel != '0));
endmodule

// File: tb/test_hwd_dual_decoder.sv
`timescale 1ns/1ps
module test_hwd_dual_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, rd_strobe = 1'b0, wr_en = 1'b0, wr_strobe = 1'b0;
  logic [15:0] rd_addr = '0, wr_addr = '0;
  logic [3:0]   rd_quad_sel, wr_quad_sel;
  logic [7:0]   rd_blk_sel, wr_blk_sel, rd_col_sel, wr_col_sel;
  logic [255:0] rd_row_sel, wr_row_sel, wr_word_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hwd_dual_decoder i_hwd_dual_decoder (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .rd_quad_sel(rd_quad_sel), .rd_blk_sel(rd_blk_sel),
    .rd_row_sel(rd_row_sel), .rd_col_sel(rd_col_sel),
    .wr_quad_sel(wr_quad_sel), .wr_blk_sel(wr_blk_sel),
    .wr_row_sel(wr_row_sel), .wr_col_sel(wr_col_sel),
    .wr_word_en(wr_word_en));

  typedef struct packed {
    logic re; logic rs; logic [15:0] ra;
    logic we; logic ws; logic [15:0] wa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 16'hFFFF},
    '{1'b1, 1'b1, 16'h5A3C, 1'b1, 1'b1, 16'h5A3C},
    '{1'b1, 1'b0, 16'h1234, 1'b0, 1'b1, 16'h8001},
    '{1'b1, 1'b1, 16'h8765, 1'b1, 1'b1, 16'h37F9},
    '{1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'h0007},
    '{1'b1, 1'b1, 16'hC7F8, 1'b1, 1'b1, 16'hC000},
    '{1'b1, 1'b1, 16'h07F8, 1'b1, 1'b1, 16'h0808},
    '{1'b0, 1'b1, 16'h2222, 1'b1, 1'b0, 16'h2222}
  };

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected selects derived by arithmetic on the address value.
  task automatic check_port(input string p, input bit active, input int unsigned a,
                            input logic [3:0] q, input logic [7:0] b,
                            input logic [255:0] r, input logic [7:0] c);
    logic [255:0] one = 256'd1;
    check({"R1 quad ", p}, {252'd0, q}, active ? one << (a / 16384) : '0);
    check({"R2 blk ", p},  {248'd0, b}, active ? one << ((a / 2048) % 8) : '0);
    check({"R3 row ", p},  r,           active ? one << ((a / 8) % 256) : '0);
    check({"R4 col ", p},  {248'd0, c}, active ? one << (a % 8) : '0);
  endtask

  task automatic check_word(input bit active, input int unsigned a);
    logic [255:0] one = 256'd1;
    check("R8 word_en", wr_word_en, active ? one << ((a / 2048) * 8 + (a % 8)) : '0);
  endtask

  task automatic check_all_zero(input string tag);
    check({tag, " rd_quad"}, {252'd0, rd_quad_sel}, '0);
    check({tag, " rd_row"},  rd_row_sel, '0);
    check({tag, " wr_blk"},  {248'd0, wr_blk_sel}, '0);
    check({tag, " wr_col"},  {248'd0, wr_col_sel}, '0);
    check({tag, " word_en"}, wr_word_en, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all_zero("R6 reset");
    rst_n = 1'b1;

    // Table-driven walk; drive at a falling edge, sample one falling edge later.
    for (int i = 0; i < NV; i++) begin
      rd_en = VECS[i].re; rd_strobe = VECS[i].rs; rd_addr = VECS[i].ra;
      wr_en = VECS[i].we; wr_strobe = VECS[i].ws; wr_addr = VECS[i].wa;
      @(negedge clk);
      check_port("rd R7", VECS[i].re && VECS[i].rs, VECS[i].ra,
                 rd_quad_sel, rd_blk_sel, rd_row_sel, rd_col_sel);
      check_port("wr R7", VECS[i].we && VECS[i].ws, VECS[i].wa,
                 wr_quad_sel, wr_blk_sel, wr_row_sel, wr_col_sel);
      check_word(VECS[i].we && VECS[i].ws, VECS[i].wa);
    end

    // R5: strobe dropped while enable stays high clears both ports.
    rd_en = 1'b1; rd_strobe = 1'b1; rd_addr = 16'h3ABC;
    wr_en = 1'b1; wr_strobe = 1'b1; wr_addr = 16'h9999;
    @(negedge clk);
    check("R5 setup active", {255'd0, |rd_row_sel}, 256'd1);
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    @(negedge clk);
    check_all_zero("R5 strobe low");

    // R5: enable dropped while strobe stays high.
    rd_strobe = 1'b1; wr_strobe = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    rd_addr = 16'hFFFF; wr_addr = 16'h0000;
    @(negedge clk);
    check_all_zero("R5 enable low");

    // R6: asynchronous reset clears active selects without a clock edge.
    rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    check("R6 pre-reset active", {255'd0, |wr_word_en}, 256'd1);
    rst_n = 1'b0;
    #1;
    check_all_zero("R6 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule